// File: doc/BRIEF.md
# Configuration port register file

This block is the software-visible front of a DMA engine that streams a bitstream into a device configuration port. A 32-bit read/write bus reaches a control word, a lock and unlock pair, an interrupt status and mask pair, a read-only status word, the four DMA descriptor words and a miscellaneous control word. The descriptor words are written one by one. Writing the source length packs the current source address, destination address, destination length and the written source length into one command. That command enters a small queue, from which a consumer takes commands one at a time.

The block stays inert after reset until a fixed key is written to the unlock word. The lowest bit of the source address selects the completion mode of each command. When it is clear, the DMA-done flag rises as soon as the bus transfer ends. When it is set, the flag waits until the configuration port has also finished. The address handed to the consumer always has that bit cleared. Hardware events set interrupt status bits, software clears them by writing ones, and a single interrupt line is the OR of the status bits whose mask bit is clear.

Top module: `cfgport_regs`

## Requirements
- R1: While locked (after reset, until the key is written), bus writes to every offset other than 0x34 have no effect, every read returns 0, `irq` is 0 and `cmd_valid` is 0. Writing any value other than 0x757BDF0D to 0x34 leaves the block locked.
- R2: Writing 0x757BDF0D to offset 0x34 unlocks the block. Writing a word with bit 0 set to offset 0x04 locks it again, and register contents are kept.
- R3: Control (0x00) resets to 0x40000000. Its bit 30 drives `prog_n`, bit 27 drives `pr_mode` and bit 26 drives `port_en`. Bit 4 of the miscellaneous control word (0x80, reset 0) drives `loopback`.
- R4: Status (0x14) is read-only: bit 31 is 1 exactly when the command queue holds 4 commands, bit 4 follows `init_line`, and all other bits are 0. Writes to it have no effect.
- R5: Interrupt status (0x0C) resets to 0. While unlocked, a 1 on `evt_set` sets the same bit if that bit is in 0xF8F7F87F. Bits outside that set never become 1. Writing 1 clears a bit, and a set and a clear of the same bit in the same cycle leave it set.
- R6: Interrupt mask (0x10) resets to 0xFFFFFFFF. `irq` is 1 exactly when the block is unlocked and some interrupt status bit is 1 while its mask bit is 0.
- R7: A write to source length (0x20) enqueues one command into a 4-deep first-in first-out queue. The command's address is the source address (0x18) with bit 0 cleared, its wait flag is source address bit 0, and it also carries the destination address (0x1C), the written length and the destination length (0x24). `cmd_valid` is 1 when the queue is non-empty and no command is in flight. A cycle with `cmd_pop` and `cmd_valid` both high removes the head command and puts it in flight.
- R8: A source-length write while the queue is full is dropped, and it sets interrupt status bit 5.
- R9: For an in-flight command with the wait flag clear, `xfer_done` sets interrupt status bit 13. For a command with the wait flag set, bit 13 is set only once both `xfer_done` and `port_done` have been seen. In both cases, bit 12 is set and the command stops being in flight once both have been seen, whether they arrive in the same cycle or in any order.
- R10: Words 0x18, 0x1C, 0x20, 0x24, 0x10 and 0x80 read back the value last written. Unmapped offsets, 0x04 and 0x34 read 0. Read data appears in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| evt_set | input | 32 | Hardware event pulses, one per interrupt status bit |
| init_line | input | 1 | Configuration init line level |
| prog_n | output | 1 | Active-low program request |
| pr_mode | output | 1 | Partial-reconfiguration mode |
| port_en | output | 1 | Configuration port enable |
| loopback | output | 1 | Internal loopback of the configuration port |
| irq | output | 1 | Interrupt line |
| cmd_valid | output | 1 | A command is ready to be taken |
| cmd_pop | input | 1 | Consumer takes the head command |
| cmd_src | output | 32 | Head command source address, bit 0 cleared |
| cmd_dst | output | 32 | Head command destination address |
| cmd_src_len | output | 32 | Head command source length in words |
| cmd_dst_len | output | 32 | Head command destination length in words |
| cmd_wait_both | output | 1 | Head command waits for both transfer and port |
| xfer_done | input | 1 | Bus transfer of the in-flight command finished |
| port_done | input | 1 | Configuration port finished the in-flight command |

## Verification
Two functions can act on an interrupt status bit in the same cycle: a hardware event setting it and a software write of one clearing it. The bench drives both in one clock. Random event patterns are overlapped with random clear masks, and the directed cases make the overlap hit the same bit. The status word read back afterwards and the `irq` level are judged against a model in which the set wins. The same situation arises with the two completion inputs of a waiting command, which the bench also raises in one cycle and expects to produce bits 12 and 13 together.

// File: rtl/cfgport_regs.sv
module cfgport_regs #(
  parameter int          QDEPTH = 4,
  parameter logic [31:0] KEY    = 32'h757B_DF0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] evt_set,
  input  logic        init_line,
  output logic        prog_n,
  output logic        pr_mode,
  output logic        port_en,
  output logic        loopback,
  output logic        irq,
  output logic        cmd_valid,
  input  logic        cmd_pop,
  output logic [31:0] cmd_src,
  output logic [31:0] cmd_dst,
  output logic [31:0] cmd_src_len,
  output logic [31:0] cmd_dst_len,
  output logic        cmd_wait_both,
  input  logic        xfer_done,
  input  logic        port_done
);
  localparam int          PW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int          CW   = $clog2(QDEPTH + 1);
  localparam logic [31:0] IMPL = 32'hF8F7_F87F;
  localparam int          B_DMA = 13, B_BOTH = 12, B_OVF = 5;

  logic        unlocked;
  logic [31:0] ctrl_q, isr_q, imr_q, mctrl_q, src_q, dst_q, slen_q, dlen_q;

  logic [31:0] q_src [QDEPTH];
  logic [31:0] q_dst [QDEPTH];
  logic [31:0] q_sl  [QDEPTH];
  logic [31:0] q_dl  [QDEPTH];
  logic        q_w   [QDEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] q_cnt;

  logic busy, act_wait, seen_x, seen_p;

  wire wr      = bus_wr & unlocked;
  wire wr_ctrl = wr && bus_addr == 8'h00;
  wire wr_lock = wr && bus_addr == 8'h04;
  wire wr_isr  = wr && bus_addr == 8'h0C;
  wire wr_imr  = wr && bus_addr == 8'h10;
  wire wr_src  = wr && bus_addr == 8'h18;
  wire wr_dst  = wr && bus_addr == 8'h1C;
  wire wr_slen = wr && bus_addr == 8'h20;
  wire wr_dlen = wr && bus_addr == 8'h24;
  wire wr_mctl = wr && bus_addr == 8'h80;
  wire wr_key  = bus_wr && bus_addr == 8'h34 && bus_wdata == KEY;

  wire q_full = (q_cnt == CW'(QDEPTH));
  wire push   = wr_slen & ~q_full;
  wire pop    = cmd_pop & cmd_valid;
  wire ovf    = wr_slen & q_full;

  wire xd   = seen_x | xfer_done;
  wire pd   = seen_p | port_done;
  wire both = busy & xd & pd;
  wire set_dma = busy & (act_wait ? (xd & pd) : xfer_done);

  wire [31:0] hw_set = ({32{unlocked}} & evt_set)
                     | (32'(set_dma) << B_DMA)
                     | (32'(both) << B_BOTH)
                     | (32'(ovf) << B_OVF);
  wire [31:0] w1c    = wr_isr ? bus_wdata : 32'h0;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign prog_n        = ctrl_q[30];
  assign pr_mode       = ctrl_q[27];
  assign port_en       = ctrl_q[26];
  assign loopback      = mctrl_q[4];
  assign irq           = unlocked & |(isr_q & ~imr_q);
  assign cmd_valid     = unlocked & (q_cnt != '0) & ~busy;
  assign cmd_src       = q_src[rd_ptr];
  assign cmd_dst       = q_dst[rd_ptr];
  assign cmd_src_len   = q_sl[rd_ptr];
  assign cmd_dst_len   = q_dl[rd_ptr];
  assign cmd_wait_both = q_w[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      ctrl_q   <= 32'h4000_0000;
      isr_q    <= '0;
      imr_q    <= '1;
      mctrl_q  <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      slen_q   <= '0;
      dlen_q   <= '0;
    end else begin
      if (wr_key) unlocked <= 1'b1;
      else if (wr_lock && bus_wdata[0]) unlocked <= 1'b0;
      if (wr_ctrl) ctrl_q  <= bus_wdata;
      if (wr_imr)  imr_q   <= bus_wdata;
      if (wr_mctl) mctrl_q <= bus_wdata;
      if (wr_src)  src_q   <= bus_wdata;
      if (wr_dst)  dst_q   <= bus_wdata;
      if (wr_slen) slen_q  <= bus_wdata;
      if (wr_dlen) dlen_q  <= bus_wdata;
      isr_q <= ((isr_q & ~w1c) | hw_set) & IMPL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop) q_cnt <= q_cnt + 1'b1;
      else if (pop && !push) q_cnt <= q_cnt - 1'b1;
    end
  end

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_src[i] <= '0;
        q_dst[i] <= '0;
        q_sl[i]  <= '0;
        q_dl[i]  <= '0;
        q_w[i]   <= 1'b0;
      end else if (push && wr_ptr == PW'(i)) begin
        q_src[i] <= {src_q[31:1], 1'b0};
        q_dst[i] <= dst_q;
        q_sl[i]  <= bus_wdata;
        q_dl[i]  <= dlen_q;
        q_w[i]   <= src_q[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      act_wait <= 1'b0;
      seen_x   <= 1'b0;
      seen_p   <= 1'b0;
    end else if (pop) begin
      busy     <= 1'b1;
      act_wait <= cmd_wait_both;
      seen_x   <= 1'b0;
      seen_p   <= 1'b0;
    end else if (busy) begin
      busy   <= ~both;
      seen_x <= xd & ~both;
      seen_p <= pd & ~both;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_rd || !unlocked) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        8'h00:   bus_rdata <= ctrl_q;
        8'h0C:   bus_rdata <= isr_q;
        8'h10:   bus_rdata <= imr_q;
        8'h14:   bus_rdata <= {q_full, 26'b0, init_line, 4'b0};
        8'h18:   bus_rdata <= src_q;
        8'h1C:   bus_rdata <= dst_q;
        8'h20:   bus_rdata <= slen_q;
        8'h24:   bus_rdata <= dlen_q;
        8'h80:   bus_rdata <= mctrl_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_locked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!irq && !cmd_valid));
  assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q & ~IMPL) == 32'h0);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && (evt_set & IMPL) != 32'h0) |=>
      ((isr_q & $past(evt_set & IMPL)) == $past(evt_set & IMPL)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QDEPTH));
  assert_pop_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop && cmd_valid) |=> !cmd_valid);
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unlocked && bus_addr == 8'h20 && q_full) |=> (isr_q[B_OVF] && $stable(wr_ptr)));
  assert_both_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && port_done) |=> (isr_q[B_BOTH] && isr_q[B_DMA]));
endmodule

// File: tb/cfgport_regs_bench.sv
module cfgport_regs_bench;
  localparam logic [31:0] IMPL = 32'hF8F7_F87F;
  localparam logic [31:0] KEY  = 32'h757B_DF0D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, init_line = 0, cmd_pop = 0, xfer_done = 0, port_done = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, evt_set = '0;
  logic [31:0] bus_rdata, cmd_src, cmd_dst, cmd_src_len, cmd_dst_len;
  logic prog_n, pr_mode, port_en, loopback, irq, cmd_valid, cmd_wait_both;

  int n_chk = 0, n_bad = 0;
  logic [31:0] isr_m, imr_m, v;

  always #10 clk = ~clk;

  cfgport_regs u_cfgport_regs (.*);

  function automatic logic [31:0] isr_after(input logic [31:0] old, clr, set);
    return ((old & ~clr) | set) & IMPL;
  endfunction
  function automatic logic irq_of(input logic [31:0] s, m);
    return |(s & ~m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ev, input logic w, input logic [7:0] a, input logic [31:0] d);
    evt_set = ev; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    evt_set = '0; bus_wr = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step('0, 1'b1, a, d);
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_rd = 0;
  endtask
  task automatic pulse(input logic x, input logic p);
    xfer_done = x; port_done = p;
    @(negedge clk);
    xfer_done = 0; port_done = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset values, R1 locked behaviour
    chk("R3 prog_n reset", 32'(prog_n), 32'd1);
    chk("R1 irq locked", 32'(irq), 32'd0);
    chk("R1 cmd_valid locked", 32'(cmd_valid), 32'd0);
    rd(8'h00, v); chk("R1 read zero while locked", v, 32'h0);
    wr(8'h00, 32'h0C00_0000);
    wr(8'h10, 32'h0);
    wr(8'h20, 32'd9);
    step(32'hFFFF_FFFF, 1'b0, 8'h0, 32'h0);
    wr(8'h34, KEY ^ 32'h1);
    rd(8'h00, v); chk("R1 wrong key stays locked", v, 32'h0);
    chk("R1 locked write ignored pins", {29'h0, prog_n, pr_mode, port_en}, 32'h4);
    // R2 unlock
    wr(8'h34, KEY);
    rd(8'h00, v); chk("R2 unlocked ctrl reset value", v, 32'h4000_0000);
    rd(8'h10, v); chk("R6 mask reset", v, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R5 isr zero after locked events", v, 32'h0);
    chk("R7 locked push ignored", 32'(cmd_valid), 32'd0);
    // R3 control and misc pins
    wr(8'h00, 32'h0C00_0000);
    chk("R3 control pins", {29'h0, prog_n, pr_mode, port_en}, 32'h3);
    wr(8'h80, 32'h10);
    chk("R3 loopback", 32'(loopback), 32'd1);
    rd(8'h80, v); chk("R10 misc readback", v, 32'h10);
    // R4 status
    init_line = 1;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R4 status init only", v, 32'h10);
    init_line = 0;
    rd(8'h14, v); chk("R4 status init low", v, 32'h0);
    // R5/R6 random events against write-one-to-clear, including same-cycle overlap
    isr_m = '0; imr_m = 32'hFFFF_FFFF;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ev, cl;
      ev = $urandom() & $urandom();
      cl = $urandom();
      if (i % 5 == 0) cl = cl | ev;
      if (i % 7 == 0) begin
        imr_m = $urandom();
        wr(8'h10, imr_m);
      end
      if (i % 3 == 0) begin
        step(ev, 1'b1, 8'h0C, cl);
        isr_m = isr_after(isr_m, cl, ev);
      end else begin
        step(ev, 1'b0, 8'h00, 32'h0);
        isr_m = isr_after(isr_m, 32'h0, ev);
      end
      chk("R6 irq level", 32'(irq), 32'(irq_of(isr_m, imr_m)));
      rd(8'h0C, v); chk("R5 isr model", v, isr_m);
    end
    wr(8'h0C, 32'hFFFF_FFFF);
    step(32'h0000_2004, 1'b1, 8'h0C, 32'h0000_2004);
    rd(8'h0C, v); chk("R5 set wins over clear", v, 32'h0000_2004);
    wr(8'h10, 32'hFFFF_DFFF);
    chk("R6 unmasked bit raises irq", 32'(irq), 32'd1);
    wr(8'h0C, 32'h0000_2000);
    chk("R6 cleared bit drops irq", 32'(irq), 32'd0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    // R7 fill the queue
    for (int i = 0; i < 4; i++) begin
      wr(8'h18, 32'h1000_0000 + 32'(i) * 32'h100 + 32'(i % 2));
      wr(8'h1C, (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h2000_0000 + 32'(i));
      wr(8'h24, (i % 2 == 0) ? 32'h0 : 32'(i + 1));
      wr(8'h20, 32'(i + 5));
    end
    rd(8'h14, v); chk("R4 queue full flag", v, 32'h8000_0000);
    rd(8'h18, v); chk("R10 src readback", v, 32'h1000_0301);
    rd(8'h1C, v); chk("R10 dst readback", v, 32'h2000_0003);
    rd(8'h24, v); chk("R10 dst len readback", v, 32'h4);
    wr(8'h20, 32'd77);
    rd(8'h0C, v); chk("R8 overflow flag", v, 32'h20);
    rd(8'h20, v); chk("R10 src len readback", v, 32'd77);
    wr(8'h0C, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      chk("R7 cmd_valid", 32'(cmd_valid), 32'd1);
      chk("R7 src bit0 cleared", cmd_src, 32'h1000_0000 + 32'(i) * 32'h100);
      chk("R7 dst", cmd_dst, (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h2000_0000 + 32'(i));
      chk("R7 src len", cmd_src_len, 32'(i + 5));
      chk("R7 dst len", cmd_dst_len, (i % 2 == 0) ? 32'h0 : 32'(i + 1));
      chk("R7 wait flag", 32'(cmd_wait_both), 32'(i % 2));
      cmd_pop = 1; @(negedge clk); cmd_pop = 0;
      chk("R7 in flight blocks valid", 32'(cmd_valid), 32'd0);
      if (i == 0) begin
        rd(8'h14, v); chk("R4 full flag clears", v, 32'h0);
      end
      if (i == 3) begin
        pulse(1, 1);
        rd(8'h0C, v); chk("R9 same-cycle completion", v, 32'h3000);
      end else if (i % 2 == 0) begin
        pulse(1, 0);
        rd(8'h0C, v); chk("R9 no-wait done on transfer", v, 32'h2000);
        pulse(0, 1);
        rd(8'h0C, v); chk("R9 both done", v, 32'h3000);
      end else begin
        pulse(0, 1);
        rd(8'h0C, v); chk("R9 wait holds done", v, 32'h0);
        pulse(1, 0);
        rd(8'h0C, v); chk("R9 wait both done", v, 32'h3000);
      end
      wr(8'h0C, 32'hFFFF_FFFF);
    end
    chk("R7 queue drained", 32'(cmd_valid), 32'd0);
    pulse(1, 1);
    rd(8'h0C, v); chk("R9 idle completion ignored", v, 32'h0);
    // R10 unmapped and write-only words
    rd(8'h40, v); chk("R10 unmapped reads zero", v, 32'h0);
    rd(8'h34, v); chk("R10 unlock word reads zero", v, 32'h0);
    // R2 relock keeps contents
    wr(8'h10, 32'h0);
    step(32'h4, 1'b0, 8'h0, 32'h0);
    chk("R6 irq before relock", 32'(irq), 32'd1);
    wr(8'h04, 32'h1);
    chk("R2 relock silences irq", 32'(irq), 32'd0);
    rd(8'h00, v); chk("R2 relocked reads zero", v, 32'h0);
    wr(8'h34, KEY);
    rd(8'h00, v); chk("R2 contents kept", v, 32'h0C00_0000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule